// File: doc/BRIEF.md
# Secondary Clock Output Mask Controller

This block decides, for each of a set of secondary-bus clock outputs, whether the output runs or is parked at a fixed level. It does not gate clocks itself. For every output it produces a synchronous enable and a park level, which the clock buffers outside the block apply. It also reports which clock source the buffers should use: the primary clock, or an external asynchronous clock.

A ten-bit disable register drives the park decisions. After the primary reset is released, the register is loaded once from a serial pin. Loading starts in the first clock cycle in which the secondary reset is still held low. Software may later overwrite the whole register. A power-management strap pin, combined with a deep device power state, overrides everything and parks every output low.

Top module: `sclk_mask_ctrl`

## Requirements
- R1: While and directly after the primary reset, the disable register is all zero, so every `out_en` bit is 1 and every `out_lvl` bit is 0.
- R2: Serial capture starts at the first rising edge at which `rst_n` is 1 and `sec_rst_n` is 0. From that edge it takes exactly N_OUT bits, one per edge, and the first bit taken controls output 0. Further edges do not change the register.
- R3: Capture happens only once per primary reset. Later low phases of `sec_rst_n` leave the register unchanged.
- R4: A disable bit of 1 gives `out_en`=0 and `out_lvl`=1 for that output. A bit of 0 gives `out_en`=1 and `out_lvl`=0. A serial input held low therefore enables all outputs, and a serial input held high parks all outputs high.
- R5: A `sw_wr` pulse outside capture replaces the whole register with `sw_wdata`, and the outputs show the new value after that edge.
- R6: A `sw_wr` pulse at an edge where a serial bit is taken is ignored. The serial bits decide the register.
- R7: When `pm_pin` is 1 and `pwr_state` is 2 (D2) or 3 (D3hot), every `out_en` and every `out_lvl` bit is 0, whatever the register holds. Encoding of `pwr_state`: 0=D0, 1=D1, 2=D2, 3=D3hot.
- R8: When `pm_pin` is 0, `pwr_state` has no effect on the outputs. When `pm_pin` is 1, the states D0 and D1 have no effect either.
- R9: `src_async` is 1 when `async_sel_n` is 0 (use the external clock) and 0 when `async_sel_n` is 1 (use the primary clock).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Primary clock |
| rst_n | input | 1 | Primary reset, active low |
| sec_rst_n | input | 1 | Secondary reset as seen by the block, active low |
| mask_sin | input | 1 | Serial disable-mask input |
| sw_wr | input | 1 | Software write strobe for the disable register |
| sw_wdata | input | 10 | Software disable bits, bit i for output i |
| pm_pin | input | 1 | Power-management strap pin |
| pwr_state | input | 2 | Device power state (0=D0, 1=D1, 2=D2, 3=D3hot) |
| async_sel_n | input | 1 | Clock source select, 0 selects the external clock |
| out_en | output | 10 | Per-output run enable |
| out_lvl | output | 10 | Per-output park level while disabled |
| src_async | output | 1 | 1 when the external asynchronous clock is selected |

## Verification
The serial capture is driven with three streams: all low, all high, and an irregular mixed word. The all-low and all-high streams separate the enable path from the park-high path. The mixed word exposes bit-order or off-by-one errors in the shift. A table of software words against power-state and strap combinations separates the deep-state override from the non-deep states and from the strap being low. Directed sequences cover a delayed capture start, an extra serial bit after capture, a second secondary-reset pulse, and a write issued during capture.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

   typedef enum logic [1:0] {
      PS_D0    = 2'd0,
      PS_D1    = 2'd1,
      PS_D2    = 2'd2,
      PS_D3HOT = 2'd3
   } pwr_state_e;

   typedef enum logic [1:0] {
      CAP_ARMED = 2'd0,
      CAP_SHIFT = 2'd1,
      CAP_DONE  = 2'd2
   } cap_state_e;

   function automatic logic is_deep_state(input pwr_state_e ps);
      return (ps == PS_D2) || (ps == PS_D3HOT);
   endfunction

endpackage

// File: rtl/sclk_mask_capture.sv
module sclk_mask_capture
   import sclk_pkg::*;
#(
   parameter int N_OUT = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sec_rst_n,
   input  logic             mask_sin,
   input  logic             sw_wr,
   input  logic [N_OUT-1:0] sw_wdata,
   output logic [N_OUT-1:0] mask,
   output logic             cap_active
);
   localparam int CW = $clog2(N_OUT + 1);
   localparam logic [CW-1:0] LAST = CW'(N_OUT - 1);

   cap_state_e    state;
   logic [CW-1:0] cnt;

   assign cap_active = (state == CAP_SHIFT) || (state == CAP_ARMED && !sec_rst_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= CAP_ARMED;
         cnt   <= '0;
      end else begin
         case (state)
            CAP_ARMED: if (!sec_rst_n) begin
               state <= CAP_SHIFT;
               cnt   <= CW'(1);
            end
            CAP_SHIFT: if (cnt == LAST) begin
               state <= CAP_DONE;
               cnt   <= '0;
            end else begin
               cnt <= cnt + CW'(1);
            end
            default: state <= CAP_DONE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mask <= '0;
      else if (cap_active) mask <= {mask_sin, mask[N_OUT-1:1]};
      else if (sw_wr)      mask <= sw_wdata;
   end

   AST_SERIAL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      cap_active |=> mask[N_OUT-1] == $past(mask_sin)); // R2
   AST_ONCE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CAP_DONE && !sw_wr) |=> $stable(mask)); // R3
   AST_SW_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr && !cap_active) |=> mask == $past(sw_wdata)); // R5
   AST_NO_RECAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CAP_DONE) |=> (state == CAP_DONE)); // R3

endmodule

// File: rtl/sclk_pwr_override.sv
module sclk_pwr_override
   import sclk_pkg::*;
(
   input  logic       pm_pin,
   input  logic [1:0] pwr_state,
   output logic       force_off
);
   pwr_state_e ps;

   always_comb begin
      ps        = pwr_state_e'(pwr_state);
      force_off = pm_pin && is_deep_state(ps);
   end
endmodule

// File: rtl/sclk_out_stage.sv
module sclk_out_stage #(
   parameter int N_OUT   = 10,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_OUT-1:0] mask,
   input  logic             force_off,
   output logic [N_OUT-1:0] out_en,
   output logic [N_OUT-1:0] out_lvl
);
   logic [N_OUT-1:0] en_nx;
   logic [N_OUT-1:0] lvl_nx;

   for (genvar i = 0; i < N_OUT; i++) begin : g_lane
      always_comb begin
         en_nx[i]  = !force_off && !mask[i];
         lvl_nx[i] = !force_off &&  mask[i];
      end
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_en  <= '1;
            out_lvl <= '0;
         end else begin
            out_en  <= en_nx;
            out_lvl <= lvl_nx;
         end
      end
      AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         force_off |=> (out_en == '0 && out_lvl == '0)); // R7
   end else begin : g_comb
      assign out_en  = en_nx;
      assign out_lvl = lvl_nx;
      AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         force_off |-> (out_en == '0 && out_lvl == '0)); // R7
      AST_PARK_FOLLOWS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
         !force_off |-> (out_lvl == mask && out_en == ~mask)); // R4
   end

   AST_EN_LVL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      (out_en & out_lvl) == '0); // R4

endmodule

// File: rtl/sclk_mask_ctrl.sv
module sclk_mask_ctrl #(
   parameter int N_OUT   = 10,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sec_rst_n,
   input  logic             mask_sin,
   input  logic             sw_wr,
   input  logic [N_OUT-1:0] sw_wdata,
   input  logic             pm_pin,
   input  logic [1:0]       pwr_state,
   input  logic             async_sel_n,
   output logic [N_OUT-1:0] out_en,
   output logic [N_OUT-1:0] out_lvl,
   output logic             src_async
);
   if (N_OUT < 2 || N_OUT > 32) begin : g_bad_width
      $error("sclk_mask_ctrl: N_OUT must be between 2 and 32");
   end

   logic [N_OUT-1:0] mask;
   logic             cap_active;
   logic             force_off;

   sclk_mask_capture #(.N_OUT(N_OUT)) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .sec_rst_n  (sec_rst_n),
      .mask_sin   (mask_sin),
      .sw_wr      (sw_wr),
      .sw_wdata   (sw_wdata),
      .mask       (mask),
      .cap_active (cap_active)
   );

   sclk_pwr_override u_pwr (
      .pm_pin    (pm_pin),
      .pwr_state (pwr_state),
      .force_off (force_off)
   );

   sclk_out_stage #(.N_OUT(N_OUT), .OUT_REG(OUT_REG)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .mask      (mask),
      .force_off (force_off),
      .out_en    (out_en),
      .out_lvl   (out_lvl)
   );

   assign src_async = !async_sel_n;

   AST_SW_IGNORED_IN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_active && sw_wr) |=> mask[N_OUT-1] == $past(mask_sin)); // R6

endmodule

// File: tb/tb_sclk_mask_ctrl.sv
module tb_sclk_mask_ctrl;
   localparam int N = 10;

   logic         clk = 1'b0;
   logic         rst_n, sec_rst_n, mask_sin, sw_wr, pm_pin, async_sel_n;
   logic [N-1:0] sw_wdata;
   logic [1:0]   pwr_state;
   logic [N-1:0] out_en, out_lvl;
   logic         src_async;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   sclk_mask_ctrl #(.N_OUT(N)) dut (
      .clk(clk), .rst_n(rst_n), .sec_rst_n(sec_rst_n), .mask_sin(mask_sin),
      .sw_wr(sw_wr), .sw_wdata(sw_wdata), .pm_pin(pm_pin), .pwr_state(pwr_state),
      .async_sel_n(async_sel_n), .out_en(out_en), .out_lvl(out_lvl),
      .src_async(src_async)
   );

   // {sw word, pm_pin, pwr_state, expected en, expected lvl}
   localparam logic [32:0] VEC [7] = '{
      {10'h000, 1'b0, 2'd0, 10'h3FF, 10'h000},
      {10'h3FF, 1'b0, 2'd3, 10'h000, 10'h3FF},
      {10'h155, 1'b1, 2'd1, 10'h2AA, 10'h155},
      {10'h2AA, 1'b1, 2'd2, 10'h000, 10'h000},
      {10'h0F0, 1'b1, 2'd3, 10'h000, 10'h000},
      {10'h00F, 1'b0, 2'd2, 10'h3F0, 10'h00F},
      {10'h201, 1'b1, 2'd0, 10'h1FE, 10'h201}
   };

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; sec_rst_n = 1'b1; mask_sin = 1'b0; sw_wr = 1'b0;
      sw_wdata = '0; pm_pin = 1'b0; pwr_state = 2'd0;
      tick(); tick();
      rst_n = 1'b1;
   endtask

   task automatic capture(input logic [N-1:0] bits, input bit write_mid);
      sec_rst_n = 1'b0;
      for (int i = 0; i < N; i++) begin
         mask_sin = bits[i];
         sw_wr    = write_mid && (i == 4);
         sw_wdata = 10'h3FF;
         tick();
      end
      sw_wr = 1'b0; sec_rst_n = 1'b1; mask_sin = 1'b0;
   endtask

   task automatic sw_write(input logic [N-1:0] d);
      sw_wdata = d; sw_wr = 1'b1;
      tick();
      sw_wr = 1'b0;
   endtask

   initial begin
      async_sel_n = 1'b1;
      do_reset();
      #1;
      chk("R1 reset en", out_en, 10'h3FF);
      chk("R1 reset lvl", out_lvl, 10'h000);

      // R9 source select
      chk("R9 sel primary", {9'd0, src_async}, 10'd0);
      async_sel_n = 1'b0; #1;
      chk("R9 sel async", {9'd0, src_async}, 10'd1);

      // R2: no capture while secondary reset is high
      mask_sin = 1'b1;
      tick(); tick(); tick();
      chk("R2 no early start", out_en, 10'h3FF);

      // R2/R4: mixed word, bit 0 first
      capture(10'h2C5, 1'b0);
      chk("R2 mixed en", out_en, ~10'h2C5);
      chk("R4 mixed lvl", out_lvl, 10'h2C5);
      // R2: an extra bit after N does nothing
      mask_sin = 1'b1; sec_rst_n = 1'b0; tick(); sec_rst_n = 1'b1; mask_sin = 1'b0;
      chk("R2 exact count", out_lvl, 10'h2C5);
      // R3: second secondary reset pulse
      sec_rst_n = 1'b0; mask_sin = 1'b1;
      tick(); tick(); tick();
      sec_rst_n = 1'b1; mask_sin = 1'b0; tick();
      chk("R3 no recapture", out_lvl, 10'h2C5);

      // R4: all-high stream
      do_reset();
      capture(10'h3FF, 1'b0);
      chk("R4 all high en", out_en, 10'h000);
      chk("R4 all high lvl", out_lvl, 10'h3FF);

      // R4/R6: all-low stream with a write mid-capture
      do_reset();
      capture(10'h000, 1'b1);
      chk("R6 write ignored en", out_en, 10'h3FF);
      chk("R4 all low lvl", out_lvl, 10'h000);

      // Table: R5 writes, R7 override, R8 no effect
      for (int k = 0; k < 7; k++) begin
         pm_pin = 1'b0; pwr_state = 2'd0;
         sw_write(VEC[k][32:23]);
         pm_pin = VEC[k][22]; pwr_state = VEC[k][21:20];
         #1;
         chk((VEC[k][22] && VEC[k][21]) ? "R7 table en" :
             ((k == 0) ? "R5 table en" : "R8 table en"), out_en, VEC[k][19:10]);
         chk((VEC[k][22] && VEC[k][21]) ? "R7 table lvl" : "R8 table lvl",
             out_lvl, VEC[k][9:0]);
      end

      // R7 release: override lifts and mask is intact
      pm_pin = 1'b1; pwr_state = 2'd3; sw_write(10'h0C3);
      chk("R7 forced during write", out_lvl, 10'h000);
      pwr_state = 2'd0; #1;
      chk("R5 write under override kept", out_lvl, 10'h0C3);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule